// File: doc/BRIEF.md
# Crypto Engine Command Queue Sequencer

This block sits between a host register port and a block-cipher engine. The host pushes 32-bit command words into a small in-order queue. The sequencer pops the words one at a time and decodes the opcode in bits [31:26]. It then runs the requested action to completion before it looks at the next word. The actions are:

- capture a source address for the engine;
- run the engine for a number of 16-byte blocks;
- flag that a transfer has finished;
- ask an external memory mover to copy words between external memory and internal RAM;
- ask the key store to load a key table from internal RAM into one of eight key slots.

The cipher core is stood in for by a stub. The stub keeps the engine busy for a fixed number of cycles per block.

Two commands take an operand word. DMA setup is followed by an address. A memory copy is followed by an external address. The sequencer waits in place until that operand word arrives.

The host reads live busy and empty flags together with sticky event bits. The host clears the sticky bits by writing ones to them. Enabled event bits drive one level interrupt.

Key loading follows this order:

1. A memory-copy command places the 16-word key table in internal RAM. The table holds up to 32 bytes of key, then the original IV, then the updated IV.
2. A table-select command then names the slot that receives the table.

Top module: `cmdq_engine_seq`

## Requirements
- R1: After reset, the status word reads 0x200: only queue-empty (bit 9) is set, and every event bit and busy flag is clear. The enable register reads 0, `irq` is low, and `eng_busy`, `mv_req` and `kl_valid` are low.
- R2: The queue holds QDEPTH (5) words. A write to the command register (index 0) while 5 words are held is dropped and sets overflow bit 1. The words already held are executed unchanged.
- R3: Status bit 9 (queue empty) is 1 only when no word is held in the queue and no command is executing or waiting for its operand word.
- R4: Opcode 0x10 (DMA setup) takes the next queued word as the engine source address, shown on `eng_src_addr`.
- R5: Opcode 0x0E (start engine) carries the block count minus one in bits [BLK_W-1:0]. `eng_busy` (also status bit 8) stays high for exactly blocks x CYC_PER_BLK (176) cycles. No further word is popped while it is high.
- R6: Opcode 0x11 (DMA complete) sets transfer-done bit 4. Because execution is in order, this happens only after every earlier command has finished.
- R7: Opcode 0x22 (memory copy) has these fields:
  - bit 25 is the direction (0 = external to internal RAM, 1 = internal RAM to external), shown on `mv_dir`;
  - bits [12 +: WC_W] are the word count, shown on `mv_words`;
  - the next queued word is the external address, shown on `mv_ext_addr`.

  `mv_req` and its payload then stay stable until `mv_ack` is seen. Status bit 10 (DMA busy) is set meanwhile. The acknowledge sets copy-done bit 5.
- R8: Opcode 0x15 (set table) is acted on only when bits [25:24] = 3 (crypto table), bit 23 = 1 (internal-RAM source) and bit 20 = 1 (key-table marker). It then raises `kl_valid` with the slot from bits [19:17] and the RAM address from bits [16:0]. These stay stable until `kl_ready`.
- R9: A word with an undefined opcode, or a set-table word that fails the checks of R8, sets command-error bit 0 and is discarded. It causes no engine, mover or key-load activity.
- R10: Writing the status register (index 1) clears each event bit whose write-data bit is 1. An event that occurs in the same cycle wins over the clear.
- R11: The enable register (index 2) keeps bits 0, 1, 4 and 5. It reads back 0x33 after 0x33 is written. `irq` is high exactly when an event bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Register index: 0 command, 1 status, 2 enable |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the register selected by `host_addr` (combinational) |
| irq | output | 1 | Level interrupt |
| mv_req | output | 1 | Memory mover request, held until acknowledged |
| mv_dir | output | 1 | 0 external to internal RAM, 1 internal RAM to external |
| mv_ext_addr | output | 32 | External address of the copy |
| mv_words | output | WC_W | Number of 32-bit words to copy |
| mv_ack | input | 1 | Mover acknowledge, sampled while `mv_req` is high |
| kl_valid | output | 1 | Key-load request valid |
| kl_slot | output | 3 | Target key slot |
| kl_ram_addr | output | 17 | Internal RAM address of the key table |
| kl_ready | input | 1 | Key store ready; transfer on valid and ready |
| eng_busy | output | 1 | Cipher stub busy |
| eng_src_addr | output | 32 | Source address latched by DMA setup |

## Verification
The checker assumes that the mover and the key store behave as handshake partners. `mv_ack` only means something while `mv_req` is high, and `kl_ready` may stay low for any time without being withdrawn in a way the block depends on. The checker also assumes the host never writes while in reset.

The bench drives `mv_ack` and `kl_ready` only after it has seen the matching request. It holds them low for several cycles first, so that the stability properties are exercised.

All host writes are single-cycle strobes applied away from the clock edge. Overflow and same-cycle set-versus-clear are produced by back-to-back writes whose edges the bench counts exactly.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam logic [5:0] OP_ENG_RUN  = 6'h0E;
  localparam logic [5:0] OP_SRC_SET  = 6'h10;
  localparam logic [5:0] OP_XFER_END = 6'h11;
  localparam logic [5:0] OP_TBL_LOAD = 6'h15;
  localparam logic [5:0] OP_MEM_COPY = 6'h22;

  localparam int EV_CMD_ERR  = 0;
  localparam int EV_Q_OVF    = 1;
  localparam int EV_XFER     = 4;
  localparam int EV_COPY     = 5;
  localparam int EV_W        = 6;
  localparam logic [EV_W-1:0] EV_MASK = 6'h33;

  localparam int FL_ENG_BUSY = 8;
  localparam int FL_Q_EMPTY  = 9;
  localparam int FL_MV_BUSY  = 10;

  localparam logic [1:0] RI_CMD = 2'd0;
  localparam logic [1:0] RI_STS = 2'd1;
  localparam logic [1:0] RI_IEN = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC_OPND,
    ST_MEM_OPND,
    ST_ENGINE,
    ST_MOVE,
    ST_KEYLD
  } seq_state_e;

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int DEPTH = 5,
  parameter int W     = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/cmdq_csr.sv
module cmdq_csr
  import cmdq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [1:0]      host_addr,
  input  logic [31:0]     host_wdata,
  input  logic [EV_W-1:0] ev_set,
  input  logic            fl_eng_busy,
  input  logic            fl_q_empty,
  input  logic            fl_mv_busy,
  output logic [31:0]     host_rdata,
  output logic            irq
);
  logic [EV_W-1:0] sts_q, ien_q, sts_d;

  always_comb begin
    sts_d = sts_q;
    if (host_we && host_addr == RI_STS) sts_d = sts_d & ~host_wdata[EV_W-1:0];
    sts_d = (sts_d | ev_set) & EV_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      ien_q <= '0;
    end else begin
      sts_q <= sts_d;
      if (host_we && host_addr == RI_IEN) ien_q <= host_wdata[EV_W-1:0] & EV_MASK;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      RI_STS: begin
        host_rdata[EV_W-1:0]   = sts_q;
        host_rdata[FL_ENG_BUSY] = fl_eng_busy;
        host_rdata[FL_Q_EMPTY]  = fl_q_empty;
        host_rdata[FL_MV_BUSY]  = fl_mv_busy;
      end
      RI_IEN:  host_rdata[EV_W-1:0] = ien_q;
      default: host_rdata = '0;
    endcase
  end

  assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/cmdq_cipher_stub.sv
module cmdq_cipher_stub #(
  parameter int CYC_PER_BLK = 176,
  parameter int BLK_W       = 12,
  parameter int CNT_W       = BLK_W + $clog2(CYC_PER_BLK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] nblk_m1,
  output logic             busy
);
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = (CNT_W'(nblk_m1) + CNT_W'(1)) * CNT_W'(CYC_PER_BLK);
  assign busy     = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      left_q <= '0;
    else if (start)  left_q <= load_val;
    else if (busy)   left_q <= left_q - CNT_W'(1);
  end
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int WC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      head,
  input  logic             q_empty,
  output logic             pop,
  output logic             eng_start,
  output logic [BLK_W-1:0] eng_nblk_m1,
  input  logic             eng_busy,
  output logic [31:0]      eng_src_addr,
  output logic             mv_req,
  output logic             mv_dir,
  output logic [31:0]      mv_ext_addr,
  output logic [WC_W-1:0]  mv_words,
  input  logic             mv_ack,
  output logic             kl_valid,
  output logic [2:0]       kl_slot,
  output logic [16:0]      kl_ram_addr,
  input  logic             kl_ready,
  output logic [EV_W-1:0]  ev_set,
  output logic             seq_idle
);
  seq_state_e state_q, state_d;
  logic [5:0] opc;
  logic       tbl_ok;
  logic       cap_src, cap_mem_hdr, cap_mem_addr, cap_tbl;

  assign opc    = head[31:26];
  assign tbl_ok = (head[25:24] == 2'd3) && head[23] && head[20];

  always_comb begin
    state_d      = state_q;
    pop          = 1'b0;
    eng_start    = 1'b0;
    cap_src      = 1'b0;
    cap_mem_hdr  = 1'b0;
    cap_mem_addr = 1'b0;
    cap_tbl      = 1'b0;
    ev_set       = '0;
    case (state_q)
      ST_IDLE: if (!q_empty) begin
        pop = 1'b1;
        case (opc)
          OP_ENG_RUN: begin
            eng_start = 1'b1;
            state_d   = ST_ENGINE;
          end
          OP_SRC_SET:  state_d = ST_SRC_OPND;
          OP_XFER_END: ev_set[EV_XFER] = 1'b1;
          OP_MEM_COPY: begin
            cap_mem_hdr = 1'b1;
            state_d     = ST_MEM_OPND;
          end
          OP_TBL_LOAD: begin
            if (tbl_ok) begin
              cap_tbl = 1'b1;
              state_d = ST_KEYLD;
            end else begin
              ev_set[EV_CMD_ERR] = 1'b1;
            end
          end
          default: ev_set[EV_CMD_ERR] = 1'b1;
        endcase
      end
      ST_SRC_OPND: if (!q_empty) begin
        pop     = 1'b1;
        cap_src = 1'b1;
        state_d = ST_IDLE;
      end
      ST_MEM_OPND: if (!q_empty) begin
        pop          = 1'b1;
        cap_mem_addr = 1'b1;
        state_d      = ST_MOVE;
      end
      ST_ENGINE: if (!eng_busy) state_d = ST_IDLE;
      ST_MOVE: if (mv_ack) begin
        ev_set[EV_COPY] = 1'b1;
        state_d         = ST_IDLE;
      end
      ST_KEYLD: if (kl_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      eng_src_addr <= '0;
      mv_dir       <= 1'b0;
      mv_words     <= '0;
      mv_ext_addr  <= '0;
      kl_slot      <= '0;
      kl_ram_addr  <= '0;
    end else begin
      state_q <= state_d;
      if (cap_src)      eng_src_addr <= head;
      if (cap_mem_hdr) begin
        mv_dir   <= head[25];
        mv_words <= head[12 +: WC_W];
      end
      if (cap_mem_addr) mv_ext_addr <= head;
      if (cap_tbl) begin
        kl_slot     <= head[19:17];
        kl_ram_addr <= head[16:0];
      end
    end
  end

  assign eng_nblk_m1 = head[BLK_W-1:0];
  assign mv_req      = (state_q == ST_MOVE);
  assign kl_valid    = (state_q == ST_KEYLD);
  assign seq_idle    = (state_q == ST_IDLE);
endmodule

// File: rtl/cmdq_engine_seq.sv
module cmdq_engine_seq
  import cmdq_pkg::*;
#(
  parameter int QDEPTH      = 5,
  parameter int CYC_PER_BLK = 176,
  parameter int BLK_W       = 12,
  parameter int WC_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [1:0]      host_addr,
  input  logic [31:0]     host_wdata,
  output logic [31:0]     host_rdata,
  output logic            irq,
  output logic            mv_req,
  output logic            mv_dir,
  output logic [31:0]     mv_ext_addr,
  output logic [WC_W-1:0] mv_words,
  input  logic            mv_ack,
  output logic            kl_valid,
  output logic [2:0]      kl_slot,
  output logic [16:0]     kl_ram_addr,
  input  logic            kl_ready,
  output logic            eng_busy,
  output logic [31:0]     eng_src_addr
);
  localparam int QC_W = $clog2(QDEPTH + 1);

  logic             q_push, q_pop, q_full, q_empty;
  logic [31:0]      q_head;
  logic [QC_W-1:0]  q_count;
  logic             eng_start;
  logic [BLK_W-1:0] eng_nblk_m1;
  logic [EV_W-1:0]  ev_seq, ev_all;
  logic             seq_idle;
  logic             flag_qempty;

  assign q_push      = host_we && (host_addr == RI_CMD);
  assign flag_qempty = q_empty && seq_idle;

  always_comb begin
    ev_all = ev_seq;
    ev_all[EV_Q_OVF] = q_push && q_full;
  end

  cmdq_fifo #(.DEPTH(QDEPTH), .W(32), .CW(QC_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .din(host_wdata), .pop(q_pop),
    .dout(q_head), .full(q_full), .empty(q_empty), .count(q_count)
  );

  cmdq_seq #(.BLK_W(BLK_W), .WC_W(WC_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .head(q_head), .q_empty(q_empty), .pop(q_pop),
    .eng_start(eng_start), .eng_nblk_m1(eng_nblk_m1), .eng_busy(eng_busy),
    .eng_src_addr(eng_src_addr),
    .mv_req(mv_req), .mv_dir(mv_dir), .mv_ext_addr(mv_ext_addr),
    .mv_words(mv_words), .mv_ack(mv_ack),
    .kl_valid(kl_valid), .kl_slot(kl_slot), .kl_ram_addr(kl_ram_addr),
    .kl_ready(kl_ready),
    .ev_set(ev_seq), .seq_idle(seq_idle)
  );

  cmdq_cipher_stub #(.CYC_PER_BLK(CYC_PER_BLK), .BLK_W(BLK_W)) u_stub (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .nblk_m1(eng_nblk_m1), .busy(eng_busy)
  );

  cmdq_csr u_csr (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .ev_set(ev_all),
    .fl_eng_busy(eng_busy), .fl_q_empty(flag_qempty), .fl_mv_busy(mv_req),
    .host_rdata(host_rdata), .irq(irq)
  );
endmodule

// File: rtl/cmdq_engine_seq_chk.sv
module cmdq_engine_seq_chk #(
  parameter int QDEPTH = 5,
  parameter int QC_W   = 3,
  parameter int WC_W   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            eng_busy,
  input logic            mv_req,
  input logic            mv_ack,
  input logic            mv_dir,
  input logic [31:0]     mv_ext_addr,
  input logic [WC_W-1:0] mv_words,
  input logic            kl_valid,
  input logic            kl_ready,
  input logic [2:0]      kl_slot,
  input logic [16:0]     kl_ram_addr,
  input logic            flag_qempty,
  input logic [QC_W-1:0] q_count
);
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QC_W'(QDEPTH));

  a_r3_empty_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flag_qempty |-> (!eng_busy && !mv_req && !kl_valid));

  a_r5_one_unit_active: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_busy, mv_req, kl_valid}));

  a_r7_mv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && !mv_ack) |=> (mv_req && $stable(mv_dir) &&
                             $stable(mv_ext_addr) && $stable(mv_words)));

  a_r8_kl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (kl_valid && !kl_ready) |=> (kl_valid && $stable(kl_slot) && $stable(kl_ram_addr)));
endmodule

bind cmdq_engine_seq cmdq_engine_seq_chk #(.QDEPTH(QDEPTH), .QC_W(QC_W), .WC_W(WC_W)) u_chk (.*);

// File: tb/cmdq_engine_seq_tb.sv
module cmdq_engine_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq;
  logic        mv_req, mv_dir, mv_ack = 1'b0;
  logic [31:0] mv_ext_addr;
  logic [7:0]  mv_words;
  logic        kl_valid, kl_ready = 1'b0;
  logic [2:0]  kl_slot;
  logic [16:0] kl_ram_addr;
  logic        eng_busy;
  logic [31:0] eng_src_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmdq_engine_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq),
    .mv_req(mv_req), .mv_dir(mv_dir), .mv_ext_addr(mv_ext_addr),
    .mv_words(mv_words), .mv_ack(mv_ack),
    .kl_valid(kl_valid), .kl_slot(kl_slot), .kl_ram_addr(kl_ram_addr),
    .kl_ready(kl_ready),
    .eng_busy(eng_busy), .eng_src_addr(eng_src_addr)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
    host_addr = 2'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd1, v); check(v, 32'h200, "R1 status after reset");
    rd(2'd2, v); check(v, 32'h0, "R1 enable after reset");
    check({irq, eng_busy, mv_req, kl_valid}, 4'b0, "R1 outputs idle after reset");
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check(v, 32'h33, "R11 enable keeps only bits 0,1,4,5");
    wr(2'd2, 32'h33);
    rd(2'd2, v); check(v, 32'h33, "R11 enable readback 0x33");
  endtask

  task automatic t_dma_setup;
    logic [31:0] v;
    wr(2'd0, 32'h4000_0000);
    idle(2);
    rd(2'd1, v); check(v[9], 1'b0, "R3 not empty while operand awaited");
    wr(2'd0, 32'h1234_5670);
    idle(2);
    check(eng_src_addr, 32'h1234_5670, "R4 source address captured");
    rd(2'd1, v); check(v[9], 1'b1, "R3 empty after setup done");
  endtask

  task automatic t_engine_run;
    logic [31:0] v;
    int n = 0;
    wr(2'd0, 32'h3800_0001);
    wr(2'd0, 32'h4400_0000);
    rd(2'd1, v);
    check(v[4], 1'b0, "R6 transfer-done waits for engine");
    check(v[9], 1'b0, "R3 not empty while engine runs");
    check(v[8], 1'b1, "R5 busy flag in status");
    for (int i = 0; i < 2000; i++) begin
      if (eng_busy) n++;
      else if (n > 0) break;
      @(negedge clk);
    end
    check(32'(n), 32'd352, "R5 busy length for two blocks");
    rd(2'd1, v); check(v[4], 1'b0, "R5 queue held until engine done");
    idle(3);
    rd(2'd1, v); check(v[4], 1'b1, "R6 transfer-done set after engine");
    check(irq, 1'b1, "R11 irq from enabled transfer-done");
    wr(2'd1, 32'h10);
    rd(2'd1, v); check(v[5:0], 6'h0, "R10 write one clears transfer-done");
    check(irq, 1'b0, "R11 irq drops after clear");
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wr(2'd0, 32'h3800_0000);
    wr(2'd0, 32'h4000_0000);
    wr(2'd0, 32'hA000_0001);
    wr(2'd0, 32'h4000_0000);
    wr(2'd0, 32'hA000_0002);
    wr(2'd0, 32'h4000_0000);
    rd(2'd1, v); check(v[1], 1'b0, "R2 five words accepted");
    wr(2'd0, 32'hA000_0003);
    rd(2'd1, v); check(v[1], 1'b1, "R2 sixth word sets overflow");
    idle(200);
    check(eng_src_addr, 32'hA000_0002, "R2 queued words executed");
    rd(2'd1, v); check(v[9], 1'b0, "R3 dropped word left setup waiting");
    wr(2'd0, 32'hA000_0004);
    idle(3);
    check(eng_src_addr, 32'hA000_0004, "R2 overflow word was dropped");
    rd(2'd1, v); check(v[9], 1'b1, "R3 empty again");
    wr(2'd1, 32'h02);
    rd(2'd1, v); check(v[1], 1'b0, "R10 overflow cleared");
  endtask

  task automatic t_mem_copy;
    logic [31:0] v;
    wr(2'd0, 32'h8A01_0000);
    wr(2'd0, 32'hABCD_0000);
    idle(2);
    check(mv_req, 1'b1, "R7 mover request raised");
    check(mv_dir, 1'b1, "R7 direction bit 25");
    check(32'(mv_words), 32'd16, "R7 word count");
    check(mv_ext_addr, 32'hABCD_0000, "R7 external address");
    rd(2'd1, v); check(v[10], 1'b1, "R7 DMA busy flag");
    idle(5);
    check(mv_req, 1'b1, "R7 request held without ack");
    mv_ack = 1'b1;
    @(negedge clk);
    mv_ack = 1'b0;
    check(mv_req, 1'b0, "R7 request dropped after ack");
    rd(2'd1, v); check(v[5], 1'b1, "R7 copy-done set");
    wr(2'd1, 32'h20);
  endtask

  task automatic t_table_load;
    wr(2'd0, 32'h579A_0040);
    idle(1);
    check(kl_valid, 1'b1, "R8 key-load valid");
    check(32'(kl_slot), 32'd5, "R8 slot");
    check(32'(kl_ram_addr), 32'h40, "R8 ram address");
    idle(4);
    check(kl_valid, 1'b1, "R8 valid held without ready");
    kl_ready = 1'b1;
    @(negedge clk);
    kl_ready = 1'b0;
    check(kl_valid, 1'b0, "R8 valid dropped after ready");
  endtask

  task automatic t_bad_words;
    logic [31:0] v;
    bit act = 0;
    wr(2'd0, 32'hFC00_0000);
    for (int i = 0; i < 3; i++) begin
      if (eng_busy || mv_req || kl_valid) act = 1;
      @(negedge clk);
    end
    rd(2'd1, v);
    check(v[0], 1'b1, "R9 undefined opcode error");
    check(v[9], 1'b1, "R9 word discarded, queue empty");
    check(irq, 1'b1, "R11 irq from enabled error");
    wr(2'd2, 32'h00);
    check(irq, 1'b0, "R11 irq masked by enable");
    wr(2'd2, 32'h33);
    wr(2'd1, 32'h01);
    wr(2'd0, 32'h559A_0000);
    for (int i = 0; i < 3; i++) begin
      if (eng_busy || mv_req || kl_valid) act = 1;
      @(negedge clk);
    end
    check(act, 1'b0, "R9 no activity for bad words");
    rd(2'd1, v); check(v[0], 1'b1, "R9 malformed table word error");
    wr(2'd1, 32'h01);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    rd(2'd1, v); check(v[0], 1'b0, "R10 error clear before race");
    wr(2'd0, 32'hFC00_0000);
    wr(2'd1, 32'h01);
    rd(2'd1, v); check(v[0], 1'b1, "R10 event wins over same-cycle clear");
    wr(2'd1, 32'h01);
    rd(2'd1, v); check(v[0], 1'b0, "R10 later clear works");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    host_addr = 2'd1;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_enable();
    t_dma_setup();
    t_engine_run();
    t_overflow();
    t_mem_copy();
    t_table_load();
    t_bad_words();
    t_set_wins();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule